// File: doc/BRIEF.md
# High-Colour Pixel Byte-Lane Splitter

This block takes a byte-wide tap of a 16-bit-per-pixel video stream and fans every pixel out to three colour heads. With the high-colour divider on, consecutive input bytes are paired into one pixel, low byte first. The low byte is looked up in palette group 0, which feeds head 0. The high byte is looked up in palette groups 1 and 2 at the same time, and these feed heads 1 and 2. Several displays can therefore share one framebuffer by owning different bits of each pixel, and each palette decodes its own bit groups back into a colour.

Each palette group holds 6-bit red, green and blue components, and it has an 8-bit pixel mask that can be applied to the index. Table outputs are widened to 8 bits per component. The block holds no frame memory. It only re-times the stream, so the nominal 640x480 frame with a 1280-byte line pitch simply streams through it. With the divider off, every byte is one index into group 0, and heads 1 and 2 stay black. A blank flag travels with the data and darkens all three heads for the pixels it marks.

Top module: `hc_lane_splitter`

## Requirements
- R1: While reset is held (synchronous, active low), and in the cycle after it is released, `out_valid` is 0 and all three head outputs are 0. All three pixel masks come out of reset as 8'hFF.
- R2: With `hc_mode`=1, accepted bytes (`in_valid`=1) pair up as low byte then high byte, and there is one pixel per two accepted bytes. Idle cycles between the two bytes do not disturb the pairing.
- R3: With `hc_mode`=1, pixel bits 7:0 index group 0, and the result drives `out_rgb0`.
- R4: With `hc_mode`=1, pixel bits 15:8 index both group 1 and group 2, and the results drive `out_rgb1` and `out_rgb2`.
- R5: A head output is packed as R in bits 23:16, G in 15:8 and B in 7:0. Each 6-bit table component c appears as c shifted left two places.
- R6: With `mask_en`=1, each group's index is the byte ANDed with that group's mask. With `mask_en`=0, the raw byte is the index, whatever the masks hold.
- R7: A table write (`wr_en`=1, `wr_mask`=0) stores `wr_data` at entry `wr_addr` of group `wr_grp`, with R in `wr_data[17:12]`, G in `wr_data[11:6]` and B in `wr_data[5:0]`. A mask write (`wr_mask`=1) stores `wr_data[7:0]` as that group's mask. `wr_grp`=3 changes nothing.
- R8: With `hc_mode`=0, each accepted byte is one pixel that indexes group 0 only, and `out_rgb1` and `out_rgb2` are 0 for it. Clearing `hc_mode` drops a half-received pair, so the next pair starts with its low byte.
- R9: A pixel appears with `out_valid`=1 at the third rising edge, counting the edge that accepts its final byte. Pixels come out in input order. Whenever `out_valid` is 0, all head outputs are 0.
- R10: If `in_blank` is 1 on either byte of a pixel, all three heads output 0 for that pixel, and `out_valid` is still 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hc_mode | input | 1 | 1 = high-colour divider on (byte pairing) |
| mask_en | input | 1 | 1 = AND indices with the group pixel masks |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_byte | input | 8 | Tapped pixel byte |
| in_blank | input | 1 | Blanking flag for this byte |
| wr_en | input | 1 | Configuration write strobe |
| wr_mask | input | 1 | 1 = write the mask, 0 = write a table entry |
| wr_grp | input | 2 | Target palette group (0 to 2) |
| wr_addr | input | 8 | Table entry address |
| wr_data | input | 18 | Entry {R,G,B} 6 bits each, or mask in bits 7:0 |
| out_valid | output | 1 | Head outputs carry a pixel |
| out_rgb0 | output | 24 | Head 0 colour (low-byte lane) |
| out_rgb1 | output | 24 | Head 1 colour (high-byte lane, group 1) |
| out_rgb2 | output | 24 | Head 2 colour (high-byte lane, group 2) |

## Verification
The bench sweeps all 256 values through each byte lane with the masks off, at reset values, and at non-trivial values. It pairs each low byte with an unrelated high byte, so a design that swapped the lanes or sent one lane to the wrong group would show wrong colours on a head. Idle gaps are placed inside pairs, and the divider mode is toggled with a half pair pending. A design that advanced its pairing on idle cycles or kept a stale low byte would be off by one byte from that point on. Blank is marked on the low byte alone and on the high byte alone, so a design that looked at only one of them would leak colour. Every output is time-stamped against the edge that accepted its final byte, which catches an extra or a missing pipeline stage.

// File: rtl/hcs_pkg.sv
// Shared definitions for the high-colour byte-lane splitter.
// Assumes exactly three palette groups; group 0 is the low-byte lane.
package hcs_pkg;
    localparam int NUM_GRP  = 3;
    localparam int GRP_SEL_W = 2;

    // Kind of configuration write
    typedef enum logic {
        WR_ENTRY = 1'b0,
        WR_MASK  = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/hcs_byte_pair.sv
// Byte pairing stage. In high-colour mode it joins two accepted bytes,
// low first, into one registered pixel; otherwise each byte becomes one
// pixel in the low lane. Assumes hc_mode is held steady during a pair;
// clearing it drops any pending low byte.
module hcs_byte_pair #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hc_mode,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic                in_blank,
    output logic                pix_vld,
    output logic [2*BYTE_W-1:0] pix_data,
    output logic                pix_blank,
    output logic                pix_hc
);
    logic              phase_q;
    logic [BYTE_W-1:0] low_q;
    logic              low_blank_q;

    // Track pair phase and emit one pixel per pair (or per byte when off)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            low_q       <= '0;
            low_blank_q <= 1'b0;
            pix_vld     <= 1'b0;
            pix_data    <= '0;
            pix_blank   <= 1'b0;
            pix_hc      <= 1'b0;
        end else begin
            pix_vld <= 1'b0;
            if (!hc_mode) begin
                phase_q <= 1'b0;
                if (in_valid) begin
                    pix_vld   <= 1'b1;
                    pix_data  <= {{BYTE_W{1'b0}}, in_byte};
                    pix_blank <= in_blank;
                    pix_hc    <= 1'b0;
                end
            end else if (in_valid) begin
                if (!phase_q) begin
                    low_q       <= in_byte;
                    low_blank_q <= in_blank;
                    phase_q     <= 1'b1;
                end else begin
                    phase_q   <= 1'b0;
                    pix_vld   <= 1'b1;
                    pix_data  <= {in_byte, low_q};
                    pix_blank <= in_blank | low_blank_q;
                    pix_hc    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hcs_clut.sv
// One palette group: a table of packed {R,G,B} entries plus a pixel mask.
// The lookup result is registered (one cycle). The table has no reset and
// is expected to be loaded before use; the mask resets to all ones.
module hcs_clut #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_entry,
    input  logic                wr_mask,
    input  logic [IDX_W-1:0]    wr_addr,
    input  logic [3*COMP_W-1:0] wr_data,
    input  logic                mask_en,
    input  logic [IDX_W-1:0]    idx_in,
    output logic [3*COMP_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = 3 * COMP_W;

    logic [ENT_W-1:0] table_q [DEPTH];
    logic [IDX_W-1:0] mask_q;
    logic [IDX_W-1:0] idx_eff;

    // Optional masking of the incoming index
    always_comb idx_eff = mask_en ? (idx_in & mask_q) : idx_in;

    // Table write port and registered lookup
    always_ff @(posedge clk) begin
        if (wr_entry) table_q[wr_addr] <= wr_data;
        rd_data <= table_q[idx_eff];
    end

    // Pixel mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= wr_data[IDX_W-1:0];
    end
endmodule

// File: rtl/hcs_head_fmt.sv
// Head output stage: widens each table component to OUT_W bits by a left
// shift and registers the result, forcing black when killed.
// Assumes OUT_W >= COMP_W.
module hcs_head_fmt #(
    parameter int COMP_W = 6,
    parameter int OUT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kill,
    input  logic [3*COMP_W-1:0] rgb_in,
    output logic [3*OUT_W-1:0]  rgb_out
);
    localparam int PAD = OUT_W - COMP_W;

    logic [3*OUT_W-1:0] wide;

    // Per-component widening: the component fills the upper bits
    for (genvar c = 0; c < 3; c++) begin : g_comp
        assign wide[c*OUT_W +: OUT_W] = {rgb_in[c*COMP_W +: COMP_W], {PAD{1'b0}}};
    end

    // Registered head drive
    always_ff @(posedge clk) begin
        if (!rst_n)    rgb_out <= '0;
        else if (kill) rgb_out <= '0;
        else           rgb_out <= wide;
    end
endmodule

// File: rtl/hc_lane_splitter.sv
// Top of the byte-lane splitter. Stage 1 pairs bytes into pixels, stage 2
// looks up the three palette groups, and stage 3 formats the heads.
// Group 0 reads the low byte; groups 1 and 2 read the high byte.
module hc_lane_splitter #(
    parameter int BYTE_W = 8,
    parameter int COMP_W = 6,
    parameter int OUT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hc_mode,
    input  logic                           mask_en,
    input  logic                           in_valid,
    input  logic [BYTE_W-1:0]              in_byte,
    input  logic                           in_blank,
    input  logic                           wr_en,
    input  logic                           wr_mask,
    input  logic [hcs_pkg::GRP_SEL_W-1:0]  wr_grp,
    input  logic [BYTE_W-1:0]              wr_addr,
    input  logic [3*COMP_W-1:0]            wr_data,
    output logic                           out_valid,
    output logic [3*OUT_W-1:0]             out_rgb0,
    output logic [3*OUT_W-1:0]             out_rgb1,
    output logic [3*OUT_W-1:0]             out_rgb2
);
    import hcs_pkg::*;

    localparam int ENT_W = 3 * COMP_W;

    logic                pix_vld;
    logic [2*BYTE_W-1:0] pix_data;
    logic                pix_blank;
    logic                pix_hc;
    logic                s2_vld;
    logic                s2_blank;
    logic                s2_hc;
    wr_kind_e            wr_kind;
    logic [ENT_W-1:0]    grp_rd   [NUM_GRP];
    logic [3*OUT_W-1:0]  head_rgb [NUM_GRP];

    assign wr_kind = wr_kind_e'(wr_mask);

    hcs_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .hc_mode  (hc_mode),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_blank (in_blank),
        .pix_vld  (pix_vld),
        .pix_data (pix_data),
        .pix_blank(pix_blank),
        .pix_hc   (pix_hc)
    );

    // Stage-2 side-band that travels alongside the table lookups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld   <= 1'b0;
            s2_blank <= 1'b0;
            s2_hc    <= 1'b0;
        end else begin
            s2_vld   <= pix_vld;
            s2_blank <= pix_blank;
            s2_hc    <= pix_hc;
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LANE = (g == 0) ? 0 : 1;
        logic sel;
        logic kill;
        assign sel  = wr_en && (wr_grp == GRP_SEL_W'(g));
        assign kill = !s2_vld || s2_blank || ((LANE != 0) && !s2_hc);

        hcs_clut #(.IDX_W(BYTE_W), .COMP_W(COMP_W)) u_clut (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_entry(sel && (wr_kind == WR_ENTRY)),
            .wr_mask (sel && (wr_kind == WR_MASK)),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .mask_en (mask_en),
            .idx_in  (pix_data[LANE*BYTE_W +: BYTE_W]),
            .rd_data (grp_rd[g])
        );

        hcs_head_fmt #(.COMP_W(COMP_W), .OUT_W(OUT_W)) u_fmt (
            .clk    (clk),
            .rst_n  (rst_n),
            .kill   (kill),
            .rgb_in (grp_rd[g]),
            .rgb_out(head_rgb[g])
        );
    end

    // Output valid follows the stage-2 valid by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s2_vld;
    end

    assign out_rgb0 = head_rgb[0];
    assign out_rgb1 = head_rgb[1];
    assign out_rgb2 = head_rgb[2];
endmodule

// File: rtl/hcs_checker.sv
// Property checker for hc_lane_splitter, attached by bind. It watches the
// stage boundaries and the head outputs.
module hcs_checker #(
    parameter int OUT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_vld,
    input logic               pix_hc,
    input logic               s2_vld,
    input logic               s2_blank,
    input logic               s2_hc,
    input logic               out_valid,
    input logic [3*OUT_W-1:0] out_rgb0,
    input logic [3*OUT_W-1:0] out_rgb1,
    input logic [3*OUT_W-1:0] out_rgb2
);
    logic was_rst;

    // Remember that reset was applied at the last edge
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: quiet outputs right after a reset edge
    always @(negedge clk) begin
        if (was_rst) begin
            a_r1_reset_idle: assert (!out_valid && out_rgb0 == '0 && out_rgb1 == '0 && out_rgb2 == '0);
        end
    end

    // R2: a completed pair is never followed at once by another pair
    a_r2_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_hc) |=> !(pix_vld && pix_hc));

    // R9: fixed latency from a stage-1 pixel to the head outputs
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> ##2 out_valid);

    // R10: a blanked pixel darkens every head while still marked valid
    a_r10_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && s2_blank) |=> (out_valid && out_rgb0 == '0 && out_rgb1 == '0 && out_rgb2 == '0));

    // R8: pixels from divider-off mode leave the high-lane heads black
    a_r8_off_black: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && !s2_hc) |=> (out_rgb1 == '0 && out_rgb2 == '0));
endmodule

bind hc_lane_splitter hcs_checker #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_vld  (pix_vld),
    .pix_hc   (pix_hc),
    .s2_vld   (s2_vld),
    .s2_blank (s2_blank),
    .s2_hc    (s2_hc),
    .out_valid(out_valid),
    .out_rgb0 (out_rgb0),
    .out_rgb1 (out_rgb1),
    .out_rgb2 (out_rgb2)
);

// File: tb/hc_lane_splitter_tb.sv
// Self-checking bench: sweeps both byte lanes against a computed palette.
module hc_lane_splitter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hc_mode = 1'b0;
    logic        mask_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_blank = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_mask = 1'b0;
    logic [1:0]  wr_grp = '0;
    logic [7:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic        out_valid;
    logic [23:0] out_rgb0, out_rgb1, out_rgb2;

    hc_lane_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .hc_mode(hc_mode), .mask_en(mask_en),
        .in_valid(in_valid), .in_byte(in_byte), .in_blank(in_blank),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_grp(wr_grp), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_valid(out_valid),
        .out_rgb0(out_rgb0), .out_rgb1(out_rgb1), .out_rgb2(out_rgb2)
    );

    always #2 clk = ~clk; // 250 MHz

    int n_chk = 0;
    int n_bad = 0;
    int ncyc = 0;
    always @(posedge clk) ncyc <= ncyc + 1;

    logic [23:0] exp0 [2048];
    logic [23:0] exp1 [2048];
    logic [23:0] exp2 [2048];
    int          exp_t [2048];
    string       exp_tag [2048];
    int wp = 0;
    int rp = 0;
    logic [7:0] bmask [3];
    logic       b_men = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Computed palette contents, R|G|B 6 bits each
    function automatic logic [17:0] pal(input int g, input int i);
        logic [5:0] r, gg, b;
        r  = 6'((i * 5 + g * 11) & 63);
        gg = 6'((i ^ (g * 19 + 7)) & 63);
        b  = 6'(((i >> 2) + g * 23 + i) & 63);
        return {r, gg, b};
    endfunction

    // R5: widening by a two-place left shift
    function automatic logic [23:0] widen(input logic [17:0] e);
        return {e[17:12], 2'b00, e[11:6], 2'b00, e[5:0], 2'b00};
    endfunction

    function automatic logic [23:0] head(input int g, input logic [7:0] idx);
        logic [7:0] k;
        k = b_men ? (idx & bmask[g]) : idx;
        return widen(pal(g, int'(k)));
    endfunction

    task automatic wr(input logic m, input logic [1:0] g, input logic [7:0] a, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mask = m; wr_grp = g; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_blank = 1'b0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic bl);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_blank = bl;
    endtask

    task automatic push(input logic [23:0] e0, input logic [23:0] e1, input logic [23:0] e2, input string tag);
        exp0[wp] = e0; exp1[wp] = e1; exp2[wp] = e2;
        exp_t[wp] = ncyc + 3;
        exp_tag[wp] = tag;
        wp++;
    endtask

    // High-colour pixel: low byte, optional idle gap, high byte
    task automatic send_pix(input logic [7:0] lo, input logic [7:0] hi,
                            input logic blo, input logic bhi, input bit gap, input string tag);
        put_byte(lo, blo);
        if (gap) idle(1);
        put_byte(hi, bhi);
        if (blo || bhi) push('0, '0, '0, tag);
        else            push(head(0, lo), head(1, hi), head(2, hi), tag);
    endtask

    task automatic wait_drain();
        idle(8);
        chk(rp == wp, "R9 all pixels delivered", 32'(rp), 32'(wp));
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid === 1'b1) begin
                if (rp >= wp) begin
                    chk(1'b0, "R9 unexpected output", 32'(out_rgb0), 32'd0);
                end else begin
                    chk(ncyc == exp_t[rp], {exp_tag[rp], " R9 timing"}, 32'(ncyc), 32'(exp_t[rp]));
                    chk(out_rgb0 == exp0[rp], {exp_tag[rp], " R3 head0"}, 32'(out_rgb0), 32'(exp0[rp]));
                    chk(out_rgb1 == exp1[rp], {exp_tag[rp], " R4 head1"}, 32'(out_rgb1), 32'(exp1[rp]));
                    chk(out_rgb2 == exp2[rp], {exp_tag[rp], " R4 head2"}, 32'(out_rgb2), 32'(exp2[rp]));
                    rp++;
                end
            end else if (out_rgb0 != '0 || out_rgb1 != '0 || out_rgb2 != '0) begin
                chk(1'b0, "R9 idle heads not black", 32'(out_rgb0 | out_rgb1 | out_rgb2), 32'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(ncyc), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int g = 0; g < 3; g++) bmask[g] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 32'd0);
        chk(out_rgb0 == '0 && out_rgb1 == '0 && out_rgb2 == '0, "R1 heads in reset",
            32'(out_rgb0 | out_rgb1 | out_rgb2), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after release", 32'(out_valid), 32'd0);

        // R7: load all three tables, then a write to group 3 that must do nothing
        for (int g = 0; g < 3; g++)
            for (int i = 0; i < 256; i++) wr(1'b0, 2'(g), 8'(i), pal(g, i));
        wr(1'b0, 2'd3, 8'd5, 18'h3FFFF);
        wr(1'b1, 2'd3, 8'd0, 18'h00000);

        // R1 R3 R4 R5: masking on with reset masks gives raw lookups
        hc_mode = 1'b1; mask_en = 1'b1; b_men = 1'b1;
        for (int i = 0; i < 256; i++) send_pix(8'(i), 8'(255 - i), 1'b0, 1'b0, 1'b0, "R1 reset-mask sweep");
        wait_drain();

        // R6 R2: masks applied, idle gaps inside some pairs
        bmask[0] = 8'h3C; bmask[1] = 8'hF0; bmask[2] = 8'h0F;
        for (int g = 0; g < 3; g++) wr(1'b1, 2'(g), 8'd0, {10'd0, bmask[g]});
        for (int i = 0; i < 256; i++) send_pix(8'(i), 8'(i * 37 + 11), 1'b0, 1'b0, (i % 3) == 0, "R6 masked R2 gaps");
        wait_drain();

        // R6: masking disabled uses raw bytes despite masks
        mask_en = 1'b0; b_men = 1'b0;
        for (int i = 0; i < 256; i++) send_pix(8'(i * 7), 8'(i), 1'b0, 1'b0, 1'b0, "R6 unmasked");
        wait_drain();

        // R10: blank on low byte only and high byte only
        for (int i = 0; i < 64; i++) send_pix(8'(i + 40), 8'(i * 3), (i % 4) == 1, (i % 4) == 2, 1'b0, "R10 blank");
        wait_drain();

        // R8: divider off, one byte per pixel into group 0
        hc_mode = 1'b0;
        idle(1);
        for (int i = 0; i < 256; i++) begin
            put_byte(8'(i), (i % 9) == 4);
            if ((i % 9) == 4) push('0, '0, '0, "R8 off blank");
            else              push(head(0, 8'(i)), '0, '0, "R8 off sweep");
        end
        wait_drain();

        // R8: clearing the mode drops a pending low byte
        hc_mode = 1'b1;
        put_byte(8'hA5, 1'b0);
        idle(1);
        hc_mode = 1'b0;
        idle(1);
        hc_mode = 1'b1;
        send_pix(8'h12, 8'hC3, 1'b0, 1'b0, 1'b0, "R8 pair realign");
        send_pix(8'h34, 8'h56, 1'b0, 1'b0, 1'b1, "R2 after realign");
        wait_drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule